// File: doc/BRIEF.md
# UART Interrupt Identification Logic

This block ranks the pending interrupt sources of a UART and presents the winner through a 32-bit read-only identification word. A single registered interrupt request line goes with the word. Four level-type sources compete under a fixed priority: receive line status, receive data available, character time-out and transmit holding empty. Each source has its own enable. The winner is reported as a 3-bit code next to an active-low pending flag. The word also carries two sticky auto-baud flags, one for successful completion and one for time-out, in dedicated bits. It also mirrors the FIFO enable setting.

A bus read is signalled by holding `rd_active` high for the length of the access. The word is frozen for as long as the read lasts. Sources that change during the read, and auto-baud events that arrive during it, are still recorded internally and show up on the next read. A read that begins while the transmit-empty code is reported acknowledges that condition. The condition returns only on a fresh rising edge of the transmit-empty level.

Top module: `uart_irq_ident`

## Requirements
- R1: After reset `id_word` reads 0x00000001 and `irq` is 0. All sticky flags and the transmit-empty pending latch are cleared.
- R2: Bit 0 is active low. It is 0 when at least one enabled source is pending and 1 otherwise. When bit 0 is 1, bits 3:1 read 000.
- R3: Bits 3:1 carry 3'b011 for line status, 3'b010 for data available, 3'b110 for character time-out and 3'b001 for transmit empty. No other code is produced.
- R4: Fixed priority, from highest: line status, data available, character time-out, transmit empty. `src_en` gates each source: bit 0 line status, bit 1 data available, bit 2 time-out, bit 3 transmit empty.
- R5: Bits 7 and 6 both equal `fifo_en`.
- R6: Bit 8 sets when `abend_pulse` occurs with `abend_en` high. Bit 9 sets when `abto_pulse` occurs with `abto_en` high. A pulse with its enable low leaves the bit unchanged.
- R7: Bits 9:8 are not cleared by reads. Each clears only when its clear strobe (`abend_clr`, `abto_clr`) pulses. If a set and a clear arrive in the same cycle, the flag stays set.
- R8: While `rd_active` is high, `id_word` holds its value. With `rd_active` low, it follows the internal state with one cycle of register latency. Source changes and events during a read appear once the read ends.
- R9: Bits 5:4 and 31:10 always read 0.
- R10: A rising edge on `thre_lvl` arms the transmit-empty pending latch. A read that starts while `id_word[3:1]` is 3'b001 clears the latch. A steady high level does not re-arm it. If an edge coincides with the clearing read, the edge wins.
- R11: `irq` is registered. It is 1 when any enabled source is pending or either auto-baud flag is set, one cycle after the internal state changes, and it is not frozen by reads.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| rls_lvl | input | 1 | Receive line status condition (level) |
| rda_lvl | input | 1 | Receive data available condition (level) |
| cti_lvl | input | 1 | Character time-out condition (level) |
| thre_lvl | input | 1 | Transmit holding empty condition (level, edge-armed) |
| src_en | input | 4 | Per-source enables: [0] line status, [1] data, [2] time-out, [3] transmit empty |
| abend_pulse | input | 1 | Auto-baud finished event |
| abto_pulse | input | 1 | Auto-baud time-out event |
| abend_en | input | 1 | Enable for the auto-baud finished flag |
| abto_en | input | 1 | Enable for the auto-baud time-out flag |
| abend_clr | input | 1 | Clear strobe for bit 8 |
| abto_clr | input | 1 | Clear strobe for bit 9 |
| fifo_en | input | 1 | FIFO enable setting, mirrored in bits 7:6 |
| rd_active | input | 1 | High while the identification word is being read |
| id_word | output | 32 | Identification word |
| irq | output | 1 | Interrupt request |

## Verification
The assertions assume that `rst` is held for at least one clock and that the inputs change only between clock edges. They assume nothing else about the order or overlap of strobes. The stimulus drives every input on the falling edge. It holds each read window for whole cycles and samples two cycles after any change, which covers the edge detector or sticky flag plus the output register. Combined set and clear strobes and events that land inside a read are applied on purpose to exercise the freeze and the set-wins rule.

// File: rtl/uart_irq_pkg.sv
package uart_irq_pkg;

    localparam int WORD_W = 32;
    localparam int CODE_W = 3;

    localparam logic [CODE_W-1:0] CODE_NONE = 3'b000;
    localparam logic [CODE_W-1:0] CODE_LINE = 3'b011;
    localparam logic [CODE_W-1:0] CODE_DATA = 3'b010;
    localparam logic [CODE_W-1:0] CODE_TOUT = 3'b110;
    localparam logic [CODE_W-1:0] CODE_TXE  = 3'b001;

    typedef struct packed {
        logic txe;
        logic tout;
        logic data;
        logic line;
    } src_vec_t;

    typedef struct packed {
        logic              pending;
        logic [CODE_W-1:0] code;
    } verdict_t;

    function automatic verdict_t rank_sources(src_vec_t s);
        verdict_t v;
        v.pending = 1'b1;
        if (s.line)      v.code = CODE_LINE;
        else if (s.data) v.code = CODE_DATA;
        else if (s.tout) v.code = CODE_TOUT;
        else if (s.txe)  v.code = CODE_TXE;
        else begin
            v.pending = 1'b0;
            v.code    = CODE_NONE;
        end
        return v;
    endfunction

    function automatic logic [WORD_W-1:0] pack_word(verdict_t v, logic fifo, logic [1:0] ab);
        logic [WORD_W-1:0] w;
        w      = '0;
        w[0]   = ~v.pending;
        w[3:1] = v.code;
        w[7:6] = {2{fifo}};
        w[9:8] = ab;
        return w;
    endfunction

endpackage

// File: rtl/uart_irq_abflag.sv
module uart_irq_abflag (
    input  logic clk,
    input  logic rst,
    input  logic evt,
    input  logic en,
    input  logic clr,
    output logic flag
);
    logic set_now;
    assign set_now = evt & en;

    always_ff @(posedge clk) begin
        if (rst)          flag <= 1'b0;
        else if (set_now) flag <= 1'b1;
        else if (clr)     flag <= 1'b0;
    end
endmodule

// File: rtl/uart_irq_txe_arm.sv
module uart_irq_txe_arm (
    input  logic clk,
    input  logic rst,
    input  logic lvl,
    input  logic ack,
    output logic pend
);
    logic lvl_q;
    logic rise;
    assign rise = lvl & ~lvl_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            lvl_q <= 1'b0;
            pend  <= 1'b0;
        end else begin
            lvl_q <= lvl;
            if (rise)     pend <= 1'b1;
            else if (ack) pend <= 1'b0;
        end
    end
endmodule

// File: rtl/uart_irq_ident.sv
module uart_irq_ident
    import uart_irq_pkg::*;
#(
    parameter int NUM_AB = 2
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              rls_lvl,
    input  logic              rda_lvl,
    input  logic              cti_lvl,
    input  logic              thre_lvl,
    input  logic [3:0]        src_en,
    input  logic              abend_pulse,
    input  logic              abto_pulse,
    input  logic              abend_en,
    input  logic              abto_en,
    input  logic              abend_clr,
    input  logic              abto_clr,
    input  logic              fifo_en,
    input  logic              rd_active,
    output logic [WORD_W-1:0] id_word,
    output logic              irq
);
    localparam logic [WORD_W-1:0] RESET_WORD = {{(WORD_W-1){1'b0}}, 1'b1};

    logic [NUM_AB-1:0] ab_evt, ab_en, ab_clr, ab_flag;
    assign ab_evt = {abto_pulse, abend_pulse};
    assign ab_en  = {abto_en, abend_en};
    assign ab_clr = {abto_clr, abend_clr};

    genvar gi;
    generate
        for (gi = 0; gi < NUM_AB; gi++) begin : g_ab
            uart_irq_abflag u_flag (
                .clk  (clk),
                .rst  (rst),
                .evt  (ab_evt[gi]),
                .en   (ab_en[gi]),
                .clr  (ab_clr[gi]),
                .flag (ab_flag[gi])
            );
        end
    endgenerate

    logic rd_q;
    logic txe_ack;
    logic txe_pend;
    assign txe_ack = rd_active & ~rd_q & (id_word[3:1] == CODE_TXE) & ~id_word[0];

    uart_irq_txe_arm u_txe (
        .clk  (clk),
        .rst  (rst),
        .lvl  (thre_lvl),
        .ack  (txe_ack),
        .pend (txe_pend)
    );

    src_vec_t          live_src;
    verdict_t          live_v;
    logic [WORD_W-1:0] live_word;

    always_comb begin
        live_src.line = rls_lvl  & src_en[0];
        live_src.data = rda_lvl  & src_en[1];
        live_src.tout = cti_lvl  & src_en[2];
        live_src.txe  = txe_pend & src_en[3];
        live_v        = rank_sources(live_src);
        live_word     = pack_word(live_v, fifo_en, ab_flag[1:0]);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            id_word <= RESET_WORD;
            irq     <= 1'b0;
            rd_q    <= 1'b0;
        end else begin
            rd_q <= rd_active;
            irq  <= live_v.pending | (|ab_flag);
            if (!rd_active) id_word <= live_word;
        end
    end
endmodule

// File: rtl/uart_irq_ident_chk.sv
module uart_irq_ident_chk (
    input logic        clk,
    input logic        rst,
    input logic        rd_active,
    input logic        fifo_en,
    input logic [31:0] id_word
);
    p_idle_zero_r2: assert property (@(posedge clk) disable iff (rst)
        id_word[0] |-> (id_word[3:1] == 3'b000));

    p_code_legal_r3: assert property (@(posedge clk) disable iff (rst)
        !id_word[0] |-> (id_word[3:1] == 3'b011 || id_word[3:1] == 3'b010 ||
                         id_word[3:1] == 3'b110 || id_word[3:1] == 3'b001));

    p_fifo_mirror_r5: assert property (@(posedge clk) disable iff (rst)
        (!$past(rd_active) && !$past(rst)) |-> (id_word[7:6] == {2{$past(fifo_en)}}));

    p_freeze_r8: assert property (@(posedge clk) disable iff (rst)
        rd_active |=> $stable(id_word));

    p_reserved_r9: assert property (@(posedge clk) disable iff (rst)
        (id_word[5:4] == 2'b00) && (id_word[31:10] == 22'd0));
endmodule

bind uart_irq_ident uart_irq_ident_chk u_chk (
    .clk       (clk),
    .rst       (rst),
    .rd_active (rd_active),
    .fifo_en   (fifo_en),
    .id_word   (id_word)
);

// File: tb/uart_irq_ident_test.sv
`timescale 1ns/1ps
module uart_irq_ident_test;
    logic clk = 1'b0;
    always #2.5 clk = ~clk;

    logic        rst;
    logic        rls_lvl, rda_lvl, cti_lvl, thre_lvl;
    logic [3:0]  src_en;
    logic        abend_pulse, abto_pulse, abend_en, abto_en, abend_clr, abto_clr;
    logic        fifo_en, rd_active;
    logic [31:0] id_word;
    logic        irq;

    int vectors = 0;
    int errors  = 0;
    bit done    = 1'b0;

    uart_irq_ident uut (
        .clk(clk), .rst(rst), .rls_lvl(rls_lvl), .rda_lvl(rda_lvl), .cti_lvl(cti_lvl),
        .thre_lvl(thre_lvl), .src_en(src_en), .abend_pulse(abend_pulse), .abto_pulse(abto_pulse),
        .abend_en(abend_en), .abto_en(abto_en), .abend_clr(abend_clr), .abto_clr(abto_clr),
        .fifo_en(fifo_en), .rd_active(rd_active), .id_word(id_word), .irq(irq)
    );

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        vectors++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual 0x%08h expected 0x%08h", tag, act, exp);
        end
    endtask

    task automatic step(input int n);
        for (int i = 0; i < n; i++) @(negedge clk);
    endtask

    function automatic logic [31:0] model(input logic l, input logic d, input logic t,
                                          input logic x, input logic [3:0] en,
                                          input logic f, input logic [1:0] ab);
        logic [31:0] w;
        logic [2:0]  c;
        logic        p;
        p = 1'b1;
        if (l & en[0])      c = 3'b011;
        else if (d & en[1]) c = 3'b010;
        else if (t & en[2]) c = 3'b110;
        else if (x & en[3]) c = 3'b001;
        else begin c = 3'b000; p = 1'b0; end
        w = 32'd0;
        w[0] = ~p;
        w[3:1] = c;
        w[7:6] = {f, f};
        w[9:8] = ab;
        return w;
    endfunction

    task automatic pulse_ab(input logic e_end, input logic e_to, input logic c_end, input logic c_to);
        abend_pulse = e_end; abto_pulse = e_to; abend_clr = c_end; abto_clr = c_to;
        step(1);
        abend_pulse = 0; abto_pulse = 0; abend_clr = 0; abto_clr = 0;
    endtask

    task automatic read1();
        rd_active = 1; step(1); rd_active = 0;
    endtask

    initial begin
        step(20000);
        if (!done) begin
            errors++;
            $display("FAIL watchdog: actual 0x%08h expected 0x%08h", 0, 1);
            $display("  == %0d vectors applied, %0d miscompares ==", vectors, errors);
            $finish;
        end
    end

    initial begin
        rst = 1; rls_lvl = 0; rda_lvl = 0; cti_lvl = 0; thre_lvl = 0; src_en = 0;
        abend_pulse = 0; abto_pulse = 0; abend_en = 0; abto_en = 0; abend_clr = 0; abto_clr = 0;
        fifo_en = 0; rd_active = 0;
        step(3);
        rst = 0;
        step(1);
        chk("R1 reset word", id_word, 32'h0000_0001);
        chk("R1 reset irq", {31'd0, irq}, 32'd0);

        // R2 R3 R4 R5 R9 R11: sweep enables, three level sources and fifo, transmit empty idle
        for (int v = 0; v < 256; v++) begin
            logic [31:0] e;
            src_en = v[7:4]; rls_lvl = v[3]; rda_lvl = v[2]; cti_lvl = v[1]; fifo_en = v[0];
            step(2);
            e = model(v[3], v[2], v[1], 1'b0, v[7:4], v[0], 2'b00);
            chk("R4 sweep word", id_word, e);
            chk("R11 sweep irq", {31'd0, irq}, {31'd0, ~e[0]});
        end
        rls_lvl = 0; rda_lvl = 0; cti_lvl = 0; fifo_en = 0; src_en = 4'b1111;
        step(2);
        chk("R2 idle", id_word, 32'h0000_0001);

        // R10 transmit empty arm / acknowledge / re-arm
        thre_lvl = 1; step(2);
        chk("R10 armed", id_word, 32'h0000_0002);
        chk("R11 txe irq", {31'd0, irq}, 32'd1);
        read1(); step(2);
        chk("R10 read clears", id_word, 32'h0000_0001);
        chk("R10 steady level no rearm", {31'd0, irq}, 32'd0);
        thre_lvl = 0; step(1); thre_lvl = 1; step(2);
        chk("R10 rearm on edge", id_word, 32'h0000_0002);
        rls_lvl = 1; step(2);
        chk("R4 line over txe", id_word, 32'h0000_0006);
        read1(); rls_lvl = 0; step(2);
        chk("R10 not acked by line read", id_word, 32'h0000_0002);
        read1(); step(2);
        chk("R10 acked", id_word, 32'h0000_0001);
        thre_lvl = 0; src_en = 4'b0111; step(2);

        // R6 R7 auto-baud flags
        pulse_ab(1, 1, 0, 0); step(2);
        chk("R6 disabled pulses ignored", id_word, 32'h0000_0001);
        chk("R6 disabled irq", {31'd0, irq}, 32'd0);
        abend_en = 1; abto_en = 1;
        pulse_ab(1, 0, 0, 0); step(2);
        chk("R6 end flag set", id_word, 32'h0000_0101);
        chk("R11 flag irq", {31'd0, irq}, 32'd1);
        read1(); step(2);
        chk("R7 read keeps flag", id_word, 32'h0000_0101);
        pulse_ab(0, 0, 1, 0); step(2);
        chk("R7 clear end flag", id_word, 32'h0000_0001);
        chk("R7 irq after clear", {31'd0, irq}, 32'd0);
        pulse_ab(0, 1, 0, 1); step(2);
        chk("R7 set wins over clear", id_word, 32'h0000_0201);
        pulse_ab(0, 0, 0, 1); step(2);
        chk("R7 clear timeout flag", id_word, 32'h0000_0001);

        // R8 freeze and deferral
        rd_active = 1; step(1);
        pulse_ab(0, 1, 0, 0);
        rda_lvl = 1; fifo_en = 1;
        step(3);
        chk("R8 frozen during read", id_word, 32'h0000_0001);
        chk("R11 irq not frozen", {31'd0, irq}, 32'd1);
        rd_active = 0; step(2);
        chk("R8 deferred events shown", id_word, 32'h0000_02C4);
        pulse_ab(0, 0, 0, 1); rda_lvl = 0; fifo_en = 0; step(2);
        chk("R9 clean end", id_word, 32'h0000_0001);

        done = 1'b1;
        $display("  == %0d vectors applied, %0d miscompares ==", vectors, errors);
        $finish;
    end
endmodule